// File: doc/BRIEF.md
# Opcode Fetch Bit-Swap Descrambler

This block sits on the read data path between program ROM and a CPU core. Some cartridge variants store their instruction opcodes with the two top data bits exchanged. When the descrambler is active, it undoes that exchange on opcode-fetch cycles only. A fetch cycle is marked by a one-cycle sync strobe from the CPU. Operand reads and data reads always pass through untouched, as do fetches when the descrambler is inactive.

Two things must both be true for the descrambler to be active:
- A static variant-select input marks the scrambled board variant.
- An enable bit is set in a configuration register. The register sits inside a 64-byte memory-mapped write window.

On reset, the enable bit loads the value of the variant input. A scrambled board therefore boots with descrambling on. Software can later turn descrambling off or on again with a single write. While reset is held, the block is forced inactive.

Top module: `opfetch_descrambler`

## Requirements
- R1: Output bits [5:0] always equal input bits [5:0], whatever the mode, strobe or reset state.
- R2: When active and the fetch strobe is high, output bit 7 equals input bit 6 and output bit 6 equals input bit 7.
- R3: When the fetch strobe is low, the output byte equals the input byte, even while active.
- R4: When the variant input is low, the output equals the input, even if the enable bit is set.
- R5: While reset is high, the output equals the input. A synchronous reset loads the enable bit with the variant input value, so after reset a scrambled variant descrambles fetches and a plain variant does not.
- R6: A write to address 0x411C (window base 0x4100, register index 0x1C) loads the enable bit from data bit 6. Only bit 6 matters. The new value governs fetches from the cycle after the write's clock edge, and a fetch in the same cycle as the write still uses the old value.
- R7: Writes to other indices in the window (for example 0x411B) leave the enable bit unchanged. So do writes outside the window, including 0x415C and 0x011C.
- R8: When write-enable is low, the address and data on the write port have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scram_variant | input | 1 | High on the scrambled board variant |
| op_sync | input | 1 | High for the one cycle in which an opcode byte is read |
| rom_data | input | 8 | Raw byte from program ROM |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_addr | input | 16 | Configuration write address |
| cfg_wr_data | input | 8 | Configuration write data |
| cpu_data | output | 8 | Byte presented to the CPU |

## Verification
The bench builds the block with its default parameters:
- an 8-bit data path;
- a 64-byte window at 0x4100;
- the enable register at index 0x1C, with the enable in bit 6;
- bits 6 and 7 as the swap pair.

These defaults put the alias addresses just outside the window within reach, such as 0x415C and 0x011C, along with the neighbouring index 0x411B. Because the variant select is an input, one build covers both board variants and switching the variant without a reset. It also covers a write issued in the same cycle as a fetch, and a write whose other data bits are set while bit 6 is clear.

// File: rtl/scr_pkg.sv
package scr_pkg;

    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [1:0] {
        CFG_IDLE,
        CFG_FOREIGN,
        CFG_OTHER_IDX,
        CFG_ENABLE
    } cfg_kind_e;

    typedef struct packed {
        logic        en;
        logic [15:0] addr;
        byte_t       data;
    } cfg_wr_t;

    function automatic int swap_src(input int bit_i, input int a, input int b);
        if (bit_i == a)      return b;
        else if (bit_i == b) return a;
        else                 return bit_i;
    endfunction

endpackage

// File: rtl/scr_cfg_reg.sv
module scr_cfg_reg
    import scr_pkg::*;
#(
    parameter int                 ADDR_W   = 16,
    parameter int                 WIN_BITS = 6,
    parameter logic [ADDR_W-1:0]  WIN_BASE = 16'h4100,
    parameter logic [WIN_BITS-1:0] EN_INDEX = 6'h1C,
    parameter int                 EN_BIT   = 6
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    variant,
    input  cfg_wr_t wr,
    output logic    en_q
);

    localparam logic [ADDR_W-1:0] EN_ADDR = WIN_BASE | ADDR_W'(EN_INDEX);

    cfg_kind_e kind;
    logic      unused_data;

    assign unused_data = ^wr.data;

    always_comb begin
        if (!wr.en)
            kind = CFG_IDLE;
        else if (wr.addr[ADDR_W-1:WIN_BITS] != WIN_BASE[ADDR_W-1:WIN_BITS])
            kind = CFG_FOREIGN;
        else if (wr.addr[WIN_BITS-1:0] != EN_INDEX)
            kind = CFG_OTHER_IDX;
        else
            kind = CFG_ENABLE;
    end

    always_ff @(posedge clk) begin
        if (rst)
            en_q <= variant;
        else if (kind == CFG_ENABLE)
            en_q <= wr.data[EN_BIT];
    end

    AST_RST_LOAD: assert property (@(posedge clk)
        rst |=> (en_q == $past(variant))); // R5

    AST_WR_LOAD: assert property (@(posedge clk) disable iff (rst)
        (wr.en && wr.addr == EN_ADDR) |=> (en_q == $past(wr.data[EN_BIT]))); // R6

    AST_WR_IGNORE: assert property (@(posedge clk) disable iff (rst)
        !(wr.en && wr.addr == EN_ADDR) |=> $stable(en_q)); // R7

endmodule

// File: rtl/scr_fetch_swap.sv
module scr_fetch_swap
    import scr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SWAP_A = 6,
    parameter int SWAP_B = 7
) (
    input  logic              act,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        localparam int SRC = swap_src(i, SWAP_A, SWAP_B);
        if (SRC == i) begin : g_keep
            assign dout[i] = din[i];
        end else begin : g_cross
            assign dout[i] = act ? din[SRC] : din[i];
        end
    end

endmodule

// File: rtl/opfetch_descrambler.sv
module opfetch_descrambler
    import scr_pkg::*;
#(
    parameter int                  ADDR_W   = 16,
    parameter int                  WIN_BITS = 6,
    parameter logic [ADDR_W-1:0]   WIN_BASE = 16'h4100,
    parameter logic [WIN_BITS-1:0] EN_INDEX = 6'h1C,
    parameter int                  EN_BIT   = 6,
    parameter int                  SWAP_A   = 6,
    parameter int                  SWAP_B   = 7
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        scram_variant,
    input  logic        op_sync,
    input  logic [7:0]  rom_data,
    input  logic        cfg_wr_en,
    input  logic [15:0] cfg_wr_addr,
    input  logic [7:0]  cfg_wr_data,
    output logic [7:0]  cpu_data
);

    cfg_wr_t wr;
    logic    en_q;
    logic    active;
    logic    do_swap;

    assign wr = '{en: cfg_wr_en, addr: cfg_wr_addr, data: cfg_wr_data};

    scr_cfg_reg #(
        .ADDR_W  (ADDR_W),
        .WIN_BITS(WIN_BITS),
        .WIN_BASE(WIN_BASE),
        .EN_INDEX(EN_INDEX),
        .EN_BIT  (EN_BIT)
    ) u_cfg (
        .clk    (clk),
        .rst    (rst),
        .variant(scram_variant),
        .wr     (wr),
        .en_q   (en_q)
    );

    assign active  = !rst && scram_variant && en_q;
    assign do_swap = active && op_sync;

    scr_fetch_swap #(
        .DATA_W(BYTE_W),
        .SWAP_A(SWAP_A),
        .SWAP_B(SWAP_B)
    ) u_swap (
        .act (do_swap),
        .din (rom_data),
        .dout(cpu_data)
    );

    AST_LOW_PASS: assert property (@(posedge clk) disable iff (rst)
        cpu_data[5:0] == rom_data[5:0]); // R1

    AST_SWAP_PAIR: assert property (@(posedge clk) disable iff (rst)
        (op_sync && scram_variant && en_q) |->
        (cpu_data[7] == rom_data[6] && cpu_data[6] == rom_data[7])); // R2

    AST_NONFETCH_PASS: assert property (@(posedge clk) disable iff (rst)
        !op_sync |-> (cpu_data == rom_data)); // R3

    AST_PLAIN_VARIANT: assert property (@(posedge clk) disable iff (rst)
        !scram_variant |-> (cpu_data == rom_data)); // R4

    AST_RST_PASS: assert property (@(posedge clk)
        rst |-> (cpu_data == rom_data)); // R5

endmodule

// File: tb/opfetch_descrambler_tb.sv
module opfetch_descrambler_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scram_variant = 1'b1;
    logic        op_sync = 1'b0;
    logic [7:0]  rom_data = 8'h00;
    logic        cfg_wr_en = 1'b0;
    logic [15:0] cfg_wr_addr = 16'h0000;
    logic [7:0]  cfg_wr_data = 8'h00;
    logic [7:0]  cpu_data;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    opfetch_descrambler u_dut (
        .clk          (clk),
        .rst          (rst),
        .scram_variant(scram_variant),
        .op_sync      (op_sync),
        .rom_data     (rom_data),
        .cfg_wr_en    (cfg_wr_en),
        .cfg_wr_addr  (cfg_wr_addr),
        .cfg_wr_data  (cfg_wr_data),
        .cpu_data     (cpu_data)
    );

    // {sync, raw byte, expected byte} with the descrambler active
    localparam logic [16:0] VEC [0:7] = '{
        {1'b1, 8'h80, 8'h40},
        {1'b1, 8'h40, 8'h80},
        {1'b1, 8'hC0, 8'hC0},
        {1'b1, 8'h3F, 8'h3F},
        {1'b0, 8'h80, 8'h80},
        {1'b0, 8'h40, 8'h40},
        {1'b1, 8'hA5, 8'h65},
        {1'b0, 8'h5A, 8'h5A}
    };

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic fetch(input logic s, input logic [7:0] b);
        @(posedge clk);
        #1;
        op_sync  = s;
        rom_data = b;
        #3;
    endtask

    task automatic cfg_write(input logic [15:0] a, input logic [7:0] d);
        @(posedge clk);
        #1;
        cfg_wr_en   = 1'b1;
        cfg_wr_addr = a;
        cfg_wr_data = d;
        @(posedge clk);
        #1;
        cfg_wr_en = 1'b0;
    endtask

    task automatic do_reset(input logic v);
        @(posedge clk);
        #1;
        rst           = 1'b1;
        scram_variant = v;
        op_sync       = 1'b1;
        rom_data      = 8'h80;
        #3;
        chk("R5 reset passthrough", cpu_data, 8'h80);
        @(posedge clk);
        #1;
        rst = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset(1'b1);
        fetch(1'b1, 8'h80);
        chk("R5 scrambled default on", cpu_data, 8'h40);

        for (int i = 0; i < 8; i++) begin
            fetch(VEC[i][16], VEC[i][15:8]);
            chk(VEC[i][16] ? "R2 R1 fetch swap" : "R3 R1 non-fetch pass",
                cpu_data, VEC[i][7:0]);
        end

        // same-cycle write and fetch: old enable still applies
        @(posedge clk);
        #1;
        cfg_wr_en   = 1'b1;
        cfg_wr_addr = 16'h411C;
        cfg_wr_data = 8'h00;
        op_sync     = 1'b1;
        rom_data    = 8'h80;
        #3;
        chk("R6 fetch during write uses old enable", cpu_data, 8'h40);
        @(posedge clk);
        #1;
        cfg_wr_en = 1'b0;
        #3;
        chk("R6 disabled after write", cpu_data, 8'h80);

        cfg_write(16'h411C, 8'h40);
        fetch(1'b1, 8'h80);
        chk("R6 re-enabled", cpu_data, 8'h40);

        cfg_write(16'h411B, 8'h00);
        fetch(1'b1, 8'h80);
        chk("R7 other index ignored", cpu_data, 8'h40);
        cfg_write(16'h415C, 8'h00);
        fetch(1'b1, 8'h80);
        chk("R7 outside window 0x415C ignored", cpu_data, 8'h40);
        cfg_write(16'h011C, 8'h00);
        fetch(1'b1, 8'h40);
        chk("R7 outside window 0x011C ignored", cpu_data, 8'h80);

        @(posedge clk);
        #1;
        cfg_wr_addr = 16'h411C;
        cfg_wr_data = 8'h00;
        cfg_wr_en   = 1'b0;
        fetch(1'b1, 8'h80);
        chk("R8 strobe low ignored", cpu_data, 8'h40);

        @(posedge clk);
        #1;
        scram_variant = 1'b0;
        fetch(1'b1, 8'h80);
        chk("R4 plain variant with enable set", cpu_data, 8'h80);
        @(posedge clk);
        #1;
        scram_variant = 1'b1;
        fetch(1'b1, 8'h80);
        chk("R4 variant restored", cpu_data, 8'h40);

        do_reset(1'b0);
        fetch(1'b1, 8'h80);
        chk("R5 plain default off", cpu_data, 8'h80);
        cfg_write(16'h411C, 8'h40);
        fetch(1'b1, 8'h80);
        chk("R4 enable written but plain variant", cpu_data, 8'h80);
        @(posedge clk);
        #1;
        scram_variant = 1'b1;
        fetch(1'b1, 8'h80);
        chk("R6 written enable takes effect", cpu_data, 8'h40);

        cfg_write(16'h411C, 8'hBF);
        fetch(1'b1, 8'h80);
        chk("R6 only bit 6 used", cpu_data, 8'h80);
        fetch(1'b1, 8'hFF);
        chk("R1 all ones", cpu_data, 8'hFF);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule